// File: doc/BRIEF.md
# Byte-Wide Data EEPROM Controller

This block sits on the external-data-space bus of an 8-bit microcontroller and decides whether each read or write strobe reaches an on-chip byte array or an off-chip data memory port. A small control register carries a memory-enable bit, a write-enable bit and a read-only ready flag. When memory-enable is clear, every strobe, address and write byte is passed to the off-chip port, and the read data comes back from it.

When memory-enable is set, a write is accepted only if write-enable is set and no program cycle is running. An accepted write latches its address and byte, drops the ready flag and runs a self-timed program cycle whose length is a parameter in clock cycles. The byte is committed to the array when that timer expires, and then the ready flag rises again. While the cycle runs, any read of the array returns the pending byte with its top bit inverted. This lets software poll for completion through the data path as well as through the ready flag.

Top module: `dee_ctrl`

## Requirements
- R1: The array holds 2^ADDR_W bytes (2048 by default, addresses 0x000 to 0x7FF). A completed write to any address is read back unchanged at that address, and other addresses are not disturbed.
- R2: With memory-enable (control bit 0) at 0, `x_rd`/`x_wr` appear on `ext_rd`/`ext_wr`, `x_addr`/`x_wdata` appear on `ext_addr`/`ext_wdata`, and `x_rdata` equals `ext_rdata`. The array and the ready flag are left unchanged.
- R3: With memory-enable at 1 and write-enable (control bit 1) at 0, a write strobe is ignored: ready stays 1 and the array is unchanged.
- R4: An accepted write holds ready (control bit 2 of `cfg_rdata`) at 0 for exactly PROG_CYCLES clock cycles after the accepting edge. After that, ready is 1.
- R5: While a program cycle runs, a read of any array address returns the byte being written with bit 7 complemented.
- R6: Once the cycle has ended, reads return the true stored byte in all eight bits.
- R7: A write strobe during a program cycle is ignored. It does not lengthen the cycle or change the address or byte being programmed.
- R8: After reset `cfg_rdata` reads 0x04: ready 1, write-enable 0, memory-enable 0.
- R9: A control write loads bits 0 and 1 from `cfg_wdata`. Bit 2 and above of `cfg_wdata` have no effect, and the upper five bits of `cfg_rdata` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write byte |
| cfg_rdata | output | 8 | Control register read: {5'b0, ready, write-enable, memory-enable} |
| x_rd | input | 1 | Data-space read strobe |
| x_wr | input | 1 | Data-space write strobe |
| x_addr | input | ADDR_W | Data-space address |
| x_wdata | input | 8 | Data-space write byte |
| x_rdata | output | 8 | Data-space read byte |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_wr | output | 1 | Off-chip write strobe |
| ext_addr | output | ADDR_W | Off-chip address |
| ext_wdata | output | 8 | Off-chip write byte |
| ext_rdata | input | 8 | Off-chip read byte |

## Verification
The bench writes every address of the array with an arithmetic pattern and reads a neighbouring address during each program cycle. A design that gated the inverted read by address, or inverted the wrong bit, would show here. It counts the busy window for every write, so a timer that is off by one cycle or restarts gives a wrong count. It issues a second write in mid-cycle: a design that re-latches would program the wrong byte or address, or run longer. Writes with write-enable clear and with memory-enable clear are each followed by a read of the target address, which exposes any leak into the array.

// File: rtl/dee_pkg.sv
package dee_pkg;
  localparam int DATA_W   = 8;
  localparam int CFG_EN   = 0;
  localparam int CFG_WEN  = 1;
  localparam int CFG_RDY  = 2;

  typedef struct packed {
    logic wen;
    logic en;
  } cfg_t;
endpackage

// File: rtl/dee_cfg_reg.sv
module dee_cfg_reg
  import dee_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] rdata
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d.en  = wdata[CFG_EN];
      cfg_d.wen = wdata[CFG_WEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata          = '0;
    rdata[CFG_EN]  = cfg_q.en;
    rdata[CFG_WEN] = cfg_q.wen;
    rdata[CFG_RDY] = ready;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/dee_prog_timer.sv
module dee_prog_timer
  import dee_pkg::*;
#(
  parameter int PROG_CYCLES = 82500,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data
);
  localparam int CW = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic              busy_q, busy_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      addr_d = start_addr;
      data_d = start_data;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy     = busy_q;
  assign commit   = done;
  assign lat_addr = addr_q;
  assign lat_data = data_q;

  // R1 / R4: an accepted write opens a cycle with the presented address and byte
  a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && lat_addr == $past(start_addr) && lat_data == $past(start_data)));
  // R4: the cycle ends right after the commit
  a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  // R4: busy does not drop before the commit
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);
  // R7: latched address and byte are frozen for the whole cycle
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_addr) && $stable(lat_data)));
endmodule

// File: rtl/dee_store.sv
module dee_store
  import dee_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              commit,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    if (busy) rd_data = {~wr_data[DATA_W-1], wr_data[DATA_W-2:0]};
    else      rd_data = mem[rd_addr];
  end
endmodule

// File: rtl/dee_ctrl.sv
module dee_ctrl
  import dee_pkg::*;
#(
  parameter int PROG_CYCLES = 82500,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              x_rd,
  input  logic              x_wr,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [7:0]        x_wdata,
  output logic [7:0]        x_rdata,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic [7:0]        ext_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  cfg_t              cfg;
  logic              busy, commit, start;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data, store_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign start = x_wr && cfg.en && cfg.wen && !busy;

  dee_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .ready (!busy),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  dee_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .start_addr (x_addr),
    .start_data (x_wdata),
    .busy       (busy),
    .commit     (commit),
    .lat_addr   (lat_addr),
    .lat_data   (lat_data)
  );

  dee_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .commit  (commit),
    .busy    (busy),
    .wr_addr (lat_addr),
    .wr_data (lat_data),
    .rd_addr (x_addr),
    .rd_data (store_rd)
  );

  assign ext_rd    = x_rd && !cfg.en;
  assign ext_wr    = x_wr && !cfg.en;
  assign ext_addr  = x_addr;
  assign ext_wdata = x_wdata;
  assign x_rdata   = cfg.en ? store_rd : ext_rdata;

  // R2 / R3: a program cycle only opens with both enable bits set
  a_r3_start_needs_enables: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(cfg_rdata[CFG_RDY]) == 1'b0 && $fell(cfg_rdata[CFG_RDY])) |-> ($past(cfg.en) && $past(cfg.wen)));
endmodule

// File: tb/dee_ctrl_tb_top.sv
module dee_ctrl_tb_top;
  localparam int P  = 5;
  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          x_rd = 1'b0, x_wr = 1'b0;
  logic [AW-1:0] x_addr = '0;
  logic [7:0]    x_wdata = '0, x_rdata;
  logic          ext_rd, ext_wr;
  logic [AW-1:0] ext_addr;
  logic [7:0]    ext_wdata, ext_rdata = '0;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dee_ctrl #(.PROG_CYCLES(P), .ADDR_W(AW)) dut_i (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 8) * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_set(logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // write strobe for one edge; returns at the negedge after the accepting edge
  task automatic wr1(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); x_wr = 1'b1; x_addr = a; x_wdata = d;
    @(negedge clk); x_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [7:0] exp);
    x_addr = a; x_rd = 1'b1; #1;
    chk(req, x_rdata, exp);
    x_rd = 1'b0;
  endtask

  // counts negedges with ready low, starting at the current negedge
  task automatic busy_len(output int len);
    len = 0;
    while (cfg_rdata[2] == 1'b0 && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R8 reset cfg", cfg_rdata, 8'h04);

    // R9: only bits 0 and 1 load, bit 2 ignored
    cfg_set(8'hFF);
    chk("R9 cfg all ones", cfg_rdata, 8'h07);
    cfg_set(8'hFC);
    chk("R9 cfg upper only", cfg_rdata, 8'h04);
    cfg_set(8'h03);
    chk("R9 cfg en+wen", cfg_rdata, 8'h07);

    // R1/R4/R5: full sweep
    for (int a = 0; a < N; a++) begin
      wr1(AW'(a), pat(a));
      rd_chk("R5 busy read", AW'(a ^ 1), pat(a) ^ 8'h80);
      busy_len(len);
      chk("R4 busy length", len, P);
    end
    @(negedge clk);
    // R1/R6: read-back
    for (int a = 0; a < N; a++) rd_chk("R1 R6 readback", AW'(a), pat(a));

    // R7: second write mid-cycle ignored
    wr1(11'h123, 8'h5A);
    @(negedge clk);
    @(negedge clk); x_wr = 1'b1; x_addr = 11'h456; x_wdata = 8'hC3;
    @(negedge clk); x_wr = 1'b0;
    rd_chk("R7 pending byte kept", 11'h456, 8'hDA);
    busy_len(len);
    chk("R7 cycle not lengthened", len + 3, P);
    rd_chk("R7 first write landed", 11'h123, 8'h5A);
    rd_chk("R7 second write dropped", 11'h456, pat(11'h456));

    // R3: write-enable clear
    cfg_set(8'h01);
    wr1(11'h005, 8'hAA);
    chk("R3 ready stays", cfg_rdata[2], 1'b1);
    rd_chk("R3 array unchanged", 11'h005, pat(5));

    // R2: memory-enable clear routes to off-chip port
    cfg_set(8'h02);
    @(negedge clk);
    ext_rdata = 8'h3C; x_addr = 11'h7FF; x_rd = 1'b1; #1;
    chk("R2 ext_rd", ext_rd, 1'b1);
    chk("R2 ext_addr", ext_addr, 11'h7FF);
    chk("R2 read data", x_rdata, 8'h3C);
    x_rd = 1'b0;
    @(negedge clk); x_wr = 1'b1; x_addr = 11'h7FF; x_wdata = 8'h99; #1;
    chk("R2 ext_wr", ext_wr, 1'b1);
    chk("R2 ext_wdata", ext_wdata, 8'h99);
    @(negedge clk); x_wr = 1'b0;
    chk("R2 ready stays", cfg_rdata[2], 1'b1);
    cfg_set(8'h03);
    rd_chk("R2 array unchanged", 11'h7FF, pat(N - 1));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule